// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between a command scheduler and the SDRAM pins of a single bank. The scheduler presents one command per clock on a valid/grant handshake. The guard grants the command only when every minimum gap that applies to it has run out. A refused request stays on the bus, and the guard raises a stall flag while it waits. When a READ is granted, the guard also produces a one-cycle pulse in the cycle its data is due, which is CAS latency clocks later.

All limits come from a 32-bit staging register that software writes at any time. The values in it do not apply at once. The whole register is decoded into an active timing set, in a single step, only when a separate program input rises from 0 to 1. Some fields hold reserved codes. For any such field, the decoder substitutes the largest legal value of that field, so a bad setting can only make the timing slower and never faster.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset the staging register reads 32'h2A733225. The active timing is then a CAS latency of 2, a REFRESH gap of 11, an ACT-to-PRE gap of 8, a PRE-to-ACT gap of 3 and an ACT-to-READ/WRITE gap of 3 clocks.
- R2: A write stores cfg_wdata in the staging register. Bits 31, 19 and 15 are always stored as 0, and cfg_rdata shows the stored value from the next cycle on.
- R3: The active timing set (CAS latency and all four gaps) reloads from the staging register, as that register stood before any write in the same cycle, only in a cycle where prog is 1 and was 0 in the previous cycle. It takes effect from the next cycle. Staging writes, a held-high prog and a falling prog do not change the active timing.
- R4: ACT-to-PRE gap, field bits 23:20: code n from 1 to 15 gives n+1 clocks, and code 0 gives 16 clocks.
- R5: REFRESH-to-REFRESH and REFRESH-to-ACT gap, field bits 27:24: code n from 1 to 15 gives n+1 clocks, and code 0 gives 16 clocks.
- R6: PRE-to-ACT gap, field bits 18:16: code n from 1 to 7 gives n clocks, and code 0 gives 7 clocks.
- R7: ACT-to-READ/WRITE gap, field bits 14:12: code n from 1 to 7 gives n clocks, and code 0 gives 7 clocks.
- R8: CAS latency, field bits 30:28: codes 2 to 7 give 2 to 7 clocks, and codes 0 and 1 give 7. A READ granted in cycle t makes rd_due high for exactly cycle t+CL. Each READ produces one such pulse, including reads granted back to back.
- R9: Command codes are ACT=0, READ=1, WRITE=2, PRE=3 and REFRESH=4. A gap of g clocks means that a command granted in cycle t allows a command that depends on that gap from cycle t+g on. In a cycle where req_valid is 1, req_grant is 1 exactly when every gap for that command has expired, and req_stall is the complement of req_grant. Both are 0 when req_valid is 0. Codes 5 to 7 are never granted.
- R10: Each gap timer restarts only on its own starting command: ACT starts ACT-to-PRE and ACT-to-READ/WRITE, PRE starts PRE-to-ACT, and REFRESH starts the REFRESH gap. READ and WRITE grants start no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_we | input | 1 | staging register write enable |
| cfg_wdata | input | 32 | staging register write data |
| cfg_rdata | output | 32 | staging register contents |
| prog | input | 1 | program level; a 0-to-1 edge loads the active timing |
| req_valid | input | 1 | scheduler presents a command |
| req_cmd | input | 3 | command code |
| req_grant | output | 1 | command issues this cycle |
| req_stall | output | 1 | command held by a running gap |
| rd_due | output | 1 | read data due this cycle |

## Verification
Directed command streams first run ACT, PRE, READ and REFRESH against the reset timing. They run again after the register is loaded with all ones, all zeros and the smallest legal codes. This separates the n, n+1 and reserved-code decodings at the exact boundary cycle of each gap. A stream run while a new value sits unprogrammed, or while prog is held high, shows whether anything other than a 0-to-1 edge reloads the timing. Random phases then mix arbitrary codes, including 5 to 7, with random register contents. They catch a wrong choice of gaps per command and a wrong timer restart, and back-to-back reads test the rd_due pipeline.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    localparam int REG_W   = 32;
    localparam int CMD_W   = 3;
    localparam int GAP_W   = 5;
    localparam int CAS_W   = 3;
    localparam int MAX_CAS = 7;
    localparam int N_GAPS  = 4;

    localparam logic [REG_W-1:0] TIM_RESET = 32'h2A733225;
    localparam logic [REG_W-1:0] KEEP_MASK = 32'h7FF77FFF;

    typedef enum logic [CMD_W-1:0] {
        CMD_ACT = 3'd0,
        CMD_RD  = 3'd1,
        CMD_WR  = 3'd2,
        CMD_PRE = 3'd3,
        CMD_REF = 3'd4
    } cmd_e;

    typedef enum int {
        G_ACT_PRE = 0,
        G_PRE_ACT = 1,
        G_ACT_RW  = 2,
        G_REF     = 3
    } gap_idx_e;

    typedef struct packed {
        logic [CAS_W-1:0] cas;
        logic [GAP_W-1:0] ref_gap;
        logic [GAP_W-1:0] act_pre;
        logic [GAP_W-1:0] pre_act;
        logic [GAP_W-1:0] act_rw;
    } timing_t;

    // n+1 coding for 4-bit fields; zero falls back to the top value
    function automatic logic [GAP_W-1:0] dec_plus1(input logic [3:0] code);
        return (code == 4'd0) ? GAP_W'(16) : GAP_W'(code) + GAP_W'(1);
    endfunction

    // direct coding for 3-bit fields; zero falls back to the top value
    function automatic logic [GAP_W-1:0] dec_direct(input logic [2:0] code);
        return (code == 3'd0) ? GAP_W'(7) : GAP_W'(code);
    endfunction

    function automatic timing_t decode(input logic [REG_W-1:0] r);
        timing_t t;
        t.cas     = (r[30:28] < 3'd2) ? CAS_W'(MAX_CAS) : r[30:28];
        t.ref_gap = dec_plus1(r[27:24]);
        t.act_pre = dec_plus1(r[23:20]);
        t.pre_act = dec_direct(r[18:16]);
        t.act_rw  = dec_direct(r[14:12]);
        return t;
    endfunction

    function automatic logic [GAP_W-1:0] gap_of(input timing_t t, input int idx);
        case (idx)
            G_ACT_PRE: return t.act_pre;
            G_PRE_ACT: return t.pre_act;
            G_ACT_RW:  return t.act_rw;
            default:   return t.ref_gap;
        endcase
    endfunction

endpackage

// File: rtl/guard_cfg.sv
module guard_cfg
    import sdram_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             prog,
    output logic [REG_W-1:0] rdata,
    output timing_t          active
);
    logic [REG_W-1:0] stage_q;
    logic             prog_q;
    timing_t          active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= TIM_RESET;
            prog_q   <= 1'b0;
            active_q <= decode(TIM_RESET);
        end else begin
            prog_q <= prog;
            if (we) begin
                stage_q <= wdata & KEEP_MASK;
            end
            if (prog && !prog_q) begin
                active_q <= decode(stage_q);
            end
        end
    end

    assign rdata  = stage_q;
    assign active = active_q;
endmodule

// File: rtl/guard_gap_timer.sv
module guard_gap_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] gap,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= gap - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/guard_rd_pipe.sv
module guard_rd_pipe #(
    parameter int DEPTH = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [SEL_W-1:0] lat,
    output logic             due
);
    logic [DEPTH-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[DEPTH-2:0], fire};
        end
    end

    // bit k holds a read granted k+1 cycles ago
    assign due = (lat == '0) ? 1'b0 : sr_q[lat - SEL_W'(1)];
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdram_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             prog,
    input  logic             req_valid,
    input  logic [CMD_W-1:0] req_cmd,
    output logic             req_grant,
    output logic             req_stall,
    output logic             rd_due
);
    timing_t            tim;
    logic [N_GAPS-1:0]  gap_start;
    logic [N_GAPS-1:0]  gap_done;
    logic               cmd_ok;

    guard_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .prog   (prog),
        .rdata  (cfg_rdata),
        .active (tim)
    );

    always_comb begin
        unique case (req_cmd)
            CMD_ACT: cmd_ok = gap_done[G_PRE_ACT] && gap_done[G_REF];
            CMD_RD,
            CMD_WR:  cmd_ok = gap_done[G_ACT_RW];
            CMD_PRE: cmd_ok = gap_done[G_ACT_PRE];
            CMD_REF: cmd_ok = gap_done[G_REF];
            default: cmd_ok = 1'b0;
        endcase
    end

    assign req_grant = req_valid && cmd_ok;
    assign req_stall = req_valid && !cmd_ok;

    always_comb begin
        gap_start            = '0;
        gap_start[G_ACT_PRE] = req_grant && (req_cmd == CMD_ACT);
        gap_start[G_ACT_RW]  = req_grant && (req_cmd == CMD_ACT);
        gap_start[G_PRE_ACT] = req_grant && (req_cmd == CMD_PRE);
        gap_start[G_REF]     = req_grant && (req_cmd == CMD_REF);
    end

    for (genvar g = 0; g < N_GAPS; g++) begin : g_timer
        guard_gap_timer #(.W(GAP_W)) u_timer (
            .clk     (clk),
            .rst     (rst),
            .start   (gap_start[g]),
            .gap     (gap_of(tim, g)),
            .expired (gap_done[g])
        );
    end

    guard_rd_pipe #(.DEPTH(MAX_CAS), .SEL_W(CAS_W)) u_rd_pipe (
        .clk  (clk),
        .rst  (rst),
        .fire (req_grant && (req_cmd == CMD_RD)),
        .lat  (tim.cas),
        .due  (rd_due)
    );
endmodule

// File: rtl/sdram_cmd_guard_chk.sv
module sdram_cmd_guard_chk
    import sdram_guard_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             req_valid,
    input logic [CMD_W-1:0] req_cmd,
    input logic             req_grant,
    input logic             req_stall
);
    // R9: a grant or a stall only with a request present
    a_r9_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (req_grant || req_stall) |-> req_valid);

    // R9: a valid request is either granted or stalled, never both
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $countones({req_grant, req_stall}) == 1);

    // R4: ACT-to-PRE is at least two clocks
    a_r4_no_pre_after_act: assert property (@(posedge clk) disable iff (rst)
        (req_grant && req_cmd == CMD_ACT) |=> !(req_grant && req_cmd == CMD_PRE));

    // R5: REFRESH-to-ACT and REFRESH-to-REFRESH are at least two clocks
    a_r5_ref_spacing: assert property (@(posedge clk) disable iff (rst)
        (req_grant && req_cmd == CMD_REF) |=>
            !(req_grant && (req_cmd == CMD_ACT || req_cmd == CMD_REF)));

    // R2: the staging register changes only through a write
    a_r2_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_rdata));

    // R2: reserved bits always read as zero
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[31] && !cfg_rdata[19] && !cfg_rdata[15]);

    // R9: codes above REFRESH are never granted
    a_r9_bad_code_refused: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cmd > CMD_REF) |-> req_stall);
endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .req_grant (req_grant),
    .req_stall (req_stall)
);

// File: tb/sdram_cmd_guard_bench.sv
module sdram_cmd_guard_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        prog = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = '0;
    logic        req_grant;
    logic        req_stall;
    logic        rd_due;

    always #2 clk = ~clk;

    sdram_cmd_guard u_sdram_cmd_guard (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .prog      (prog),
        .req_valid (req_valid),
        .req_cmd   (req_cmd),
        .req_grant (req_grant),
        .req_stall (req_stall),
        .rd_due    (rd_due)
    );

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          finished = 1'b0;

    // reference model state
    longint      cyc;
    longint      last_act, last_pre, last_ref;
    logic [31:0] m_stage;
    bit          m_prog;
    int          m_cas, m_ref, m_ap, m_pa, m_ar;
    bit          m_due [256];

    function automatic int plus1(input int code);
        return (code == 0) ? 16 : code + 1;
    endfunction

    function automatic int direct(input int code);
        return (code == 0) ? 7 : code;
    endfunction

    task automatic load_model(input logic [31:0] r);
        m_cas = (r[30:28] < 2) ? 7 : int'(r[30:28]);
        m_ref = plus1(int'(r[27:24]));
        m_ap  = plus1(int'(r[23:20]));
        m_pa  = direct(int'(r[18:16]));
        m_ar  = direct(int'(r[14:12]));
    endtask

    function automatic bit allowed(input int c);
        case (c)
            0:       return (cyc - last_pre >= m_pa) && (cyc - last_ref >= m_ref);
            1, 2:    return (cyc - last_act >= m_ar);
            3:       return (cyc - last_act >= m_ap);
            4:       return (cyc - last_ref >= m_ref);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input int c);
        case (c)
            0:       return "R6";
            1, 2:    return "R7";
            3:       return "R4";
            4:       return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    task automatic step(input bit v, input int c, input bit we,
                        input logic [31:0] wd, input bit pr);
        bit eg, es, ed;
        @(negedge clk);
        req_valid = v;
        req_cmd   = c[2:0];
        cfg_we    = we;
        cfg_wdata = wd;
        prog      = pr;
        #1;
        eg = v && allowed(c);
        es = v && !eg;
        ed = m_due[cyc % 256];
        check({req_grant, req_stall} == {eg, es}, tag_of(c), "grant/stall",
              {30'd0, req_grant, req_stall}, {30'd0, eg, es});
        check(rd_due == ed, "R8", "rd_due", {31'd0, rd_due}, {31'd0, ed});
        check(cfg_rdata == m_stage, "R2", "cfg_rdata", cfg_rdata, m_stage);
        m_due[cyc % 256] = 1'b0;
        if (eg) begin
            if (c == 0) last_act = cyc;
            if (c == 3) last_pre = cyc;
            if (c == 4) last_ref = cyc;
            if (c == 1) m_due[(cyc + m_cas) % 256] = 1'b1;
        end
        if (pr && !m_prog) load_model(m_stage);   // R3: edge only, pre-write value
        m_prog = pr;
        if (we) m_stage = wd & 32'h7FF77FFF;
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, '0, m_prog);
    endtask

    task automatic program_reg(input logic [31:0] v);
        idle(18);
        step(1'b0, 0, 1'b1, v, 1'b0);
        step(1'b0, 0, 1'b0, '0, 1'b0);
        step(1'b0, 0, 1'b0, '0, 1'b1);
        step(1'b0, 0, 1'b0, '0, 1'b0);
    endtask

    // every command requested each cycle until granted, then the next
    task automatic stream();
        int seq [10] = '{0, 1, 3, 0, 2, 1, 3, 4, 4, 0};
        for (int k = 0; k < 10; k++) begin
            for (int w = 0; w < 20; w++) begin
                bit g = allowed(seq[k]);
                step(1'b1, seq[k], 1'b0, '0, m_prog);
                if (g) break;
            end
        end
        step(1'b1, 1, 1'b0, '0, m_prog);   // R8: back-to-back reads
        step(1'b1, 1, 1'b0, '0, m_prog);
        idle(8);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        cyc = 0;
        last_act = -1000;
        last_pre = -1000;
        last_ref = -1000;
        m_prog = 1'b0;
        m_stage = 32'h2A733225;
        load_model(m_stage);
        for (int i = 0; i < 256; i++) m_due[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset contents and reset timing
        idle(1);
        stream();

        // R2: reserved bits drop; R3: staged value is not yet active
        step(1'b0, 0, 1'b1, 32'hFFFF_FFFF, 1'b0);
        idle(1);
        stream();

        // R3: edge loads all ones -> CL 7, gaps 16/16/7/7 (R4 R5 R6 R7 R8)
        step(1'b0, 0, 1'b0, '0, 1'b1);
        stream();
        // R3: writes while prog stays high do not reload
        step(1'b0, 0, 1'b1, 32'h2111_1000, 1'b1);
        stream();
        step(1'b0, 0, 1'b0, '0, 1'b0);
        stream();

        // reserved codes in every field fall back to the largest value
        program_reg(32'h0000_0000);
        stream();
        // smallest legal codes
        program_reg(32'h2111_1000);
        stream();
        // R10: reads and writes between ACT and PRE do not restart any gap
        program_reg(32'h3A973225);
        stream();

        // random phases, including codes 5 to 7 (R9)
        for (int r = 0; r < 30; r++) begin
            program_reg($urandom());
            for (int i = 0; i < 150; i++) begin
                bit v = ($urandom_range(3) != 0);
                int c = ($urandom_range(7) < 6) ? $urandom_range(4) : $urandom_range(7);
                step(v, c, 1'b0, '0, 1'b0);
            end
        end
        idle(10);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule